// File: doc/BRIEF.md
# Two-Mode Countdown Timer with Self-Locking Watchdog

This peripheral holds a 16-bit counter that software drives through four word registers on a small memory-mapped bus: a reload value, a read-only snapshot of the counter, a control word, and a clear port. The counter advances on ticks taken from an external slow-clock enable pulse. A prescaler passes every tick, every sixteenth tick or every 256th tick. In normal mode the counter runs up or down. It either wraps (free-running) or restarts from the reload value (periodic), and it raises a one-cycle interrupt each time it passes its end value.

In watchdog mode the same counter starts at the reload value and runs down toward zero. Software restarts it by writing any data to the clear port. If the counter reaches zero first, the block raises one of two outputs, chosen by a control bit: a sticky system reset request, or an interrupt that stays pending until the clear port is written. Setting the watchdog bit freezes the reload and control registers until the next reset. Software therefore programs the reload value before it sets that bit.

Register offsets on `bus_addr`: 0x0 reload, 0x4 counter, 0x8 control, 0xC clear. Writes take effect at the clock edge where `wr_en` is high. Reads are combinational while `rd_en` is high, and `rd_data` is zero otherwise.

Top module: `wdt_timer16`

## Requirements
- R1: After reset the reload register reads 0x0000, the counter reads 0xFFFF, the control word reads 0, and `irq_o` and `rst_req_o` are low.
- R2: The control word holds direction in bit 8 (1 = up), run enable in bit 7, periodic in bit 6, watchdog in bit 5, the secure-clear flag in bit 4 (stored only), prescale in bits [3:2] and the watchdog interrupt choice in bit 1. Bits 0 and [31:9] read 0. The counter offset ignores writes, and the clear offset reads 0.
- R3: Prescale code 00 advances the counter on every tick, 01 on every 16th tick and 10 on every 256th tick. Code 11 behaves like 00. The division restarts at each write to the control or clear offset.
- R4: With run enabled, down and free-running, each prescaled tick decrements the counter. From 0 it wraps to 0xFFFF and `irq_o` goes high for exactly one cycle.
- R5: Counting up, the counter increments. At 0xFFFF it wraps to 0 (free-running) or reloads from the reload register (periodic), with a one-cycle `irq_o` in both cases.
- R6: Counting down in periodic mode, a tick at 0 reloads from the reload register with a one-cycle `irq_o`. With run and watchdog both clear, ticks leave the counter unchanged.
- R7: Writing the control word with bit 5 set copies the reload value into the counter. The counter then counts down on prescaled ticks even when bit 7 is clear.
- R8: When the watchdog count reaches 0 with bit 1 clear, `rst_req_o` rises and stays high until reset.
- R9: When the watchdog count reaches 0 with bit 1 set, `irq_o` rises and stays high until a write to the clear offset.
- R10: A write of any data to the clear offset copies the reload value into the counter. If a tick arrives in the same cycle, the clear write wins and no expiry happens.
- R11: While the watchdog is active, writes to the reload and control offsets are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_in | input | 1 | Slow-clock enable pulse, one cycle per tick |
| bus_addr | input | 4 | Register byte offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, zero when rd_en is low |
| irq_o | output | 1 | Interrupt: pulse in normal mode, held in watchdog interrupt mode |
| rst_req_o | output | 1 | Sticky system reset request |

## Verification
The risky overlap is a clear write landing in the same cycle as the tick that would take the watchdog count from 1 to 0. The bench sets up this case by driving `tick_in` and the clear write together at the same edge. It judges the result by the counter reading back as the reload value, `irq_o` staying low, and the count then running a full period again. A second overlap, a tick during a control write, is settled by letting the write take precedence. Every other test drives its ticks and bus writes in separate cycles, so this rule never affects them.

// File: rtl/wdt_timer16.sv
module wdt_timer16 #(
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_in,
  input  logic [3:0]  bus_addr,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  output logic [31:0] rd_data,
  output logic        irq_o,
  output logic        rst_req_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] load_q, cnt_q;
  logic             up_q, en_q, per_q, wd_q, sec_q, wdirq_q;
  logic [1:0]       psc_q;
  logic [7:0]       pre_q;
  logic             pulse_q, pend_q, rst_q;

  wire wr_load  = wr_en && bus_addr == 4'h0 && !wd_q;
  wire wr_ctrl  = wr_en && bus_addr == 4'h8 && !wd_q;
  wire wr_clr   = wr_en && bus_addr == 4'hC;
  wire wd_entry = wr_ctrl && wr_data[5];
  wire active   = en_q || wd_q;
  wire unused_bits = ^wr_data[31:CNT_W];

  logic psc_ok;
  always_comb begin
    case (psc_q)
      2'b01:   psc_ok = pre_q[3:0] == 4'hF;
      2'b10:   psc_ok = pre_q == 8'hFF;
      default: psc_ok = 1'b1;
    endcase
  end

  wire step      = tick_in && active && psc_ok && !wr_ctrl && !wr_clr;
  wire at_term   = (up_q && !wd_q) ? (cnt_q == CNT_MAX) : (cnt_q == '0);
  wire wd_expire = step && wd_q && (cnt_q <= CNT_ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      {up_q, en_q, per_q, wd_q, sec_q, psc_q, wdirq_q} <= '0;
    end else begin
      if (wr_load) load_q <= wr_data[CNT_W-1:0];
      if (wr_ctrl) begin
        up_q    <= wr_data[8];
        en_q    <= wr_data[7];
        per_q   <= wr_data[6];
        wd_q    <= wr_data[5];
        sec_q   <= wr_data[4];
        psc_q   <= wr_data[3:2];
        wdirq_q <= wr_data[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else if (wr_ctrl || wr_clr) pre_q <= '0;
    else if (tick_in && active) pre_q <= pre_q + 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= CNT_MAX;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= step && !wd_q && at_term;
      if (wr_clr || wd_entry) cnt_q <= load_q;
      else if (step) begin
        if (wd_q)      cnt_q <= (cnt_q == '0) ? '0 : cnt_q - CNT_ONE;
        else if (up_q) cnt_q <= at_term ? (per_q ? load_q : '0) : cnt_q + CNT_ONE;
        else           cnt_q <= at_term ? (per_q ? load_q : CNT_MAX) : cnt_q - CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      if (wr_clr) pend_q <= 1'b0;
      else if (wd_expire && wdirq_q) pend_q <= 1'b1;
      if (wd_expire && !wdirq_q) rst_q <= 1'b1;
    end
  end

  assign irq_o     = pulse_q || pend_q;
  assign rst_req_o = rst_q;

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (bus_addr)
        4'h0: rd_data = 32'(load_q);
        4'h4: rd_data = 32'(cnt_q);
        4'h8: rd_data = {23'd0, up_q, en_q, per_q, wd_q, sec_q, psc_q, wdirq_q, 1'b0};
        default: rd_data = '0;
      endcase
    end
  end

  AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> rst_q);  // R8
  AST_WD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    wd_q |=> wd_q);  // R11
  AST_LOAD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_q && wr_en && bus_addr == 4'h0) |=> $stable(load_q));  // R11
  AST_CLR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> cnt_q == $past(load_q));  // R10
  AST_WD_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_q && !wr_clr) |=> cnt_q <= $past(cnt_q));  // R7
  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !wr_clr) |=> pend_q);  // R9

endmodule

// File: tb/test_wdt_timer16.sv
module test_wdt_timer16;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_in = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        irq_o, rst_req_o;
  int total = 0;
  int bad = 0;
  bit done = 0;

  wdt_timer16 i_wdt_timer16 (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .bus_addr(bus_addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .irq_o(irq_o), .rst_req_o(rst_req_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_in = 1'b1;
      @(negedge clk);
      tick_in = 1'b0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    bus_rd(4'h0, v); check("R1 load", v, 32'h0);
    bus_rd(4'h4, v); check("R1 value", v, 32'hFFFF);
    bus_rd(4'h8, v); check("R1 ctrl", v, 32'h0);
    check("R1 irq", {31'd0, irq_o}, 0);
    check("R1 rst_req", {31'd0, rst_req_o}, 0);
    ticks(3);
    bus_rd(4'h4, v); check("R6 disabled no count", v, 32'hFFFF);
  endtask

  task automatic t_ctrl_image();
    logic [31:0] v;
    do_reset();
    bus_wr(4'h8, 32'hFFFF_FFDF);
    bus_rd(4'h8, v); check("R2 ctrl image", v, 32'h1DE);
    bus_wr(4'h4, 32'h1234);
    bus_rd(4'h4, v); check("R2 value write ignored", v, 32'hFFFF);
    bus_rd(4'hC, v); check("R2 clear reads 0", v, 32'h0);
  endtask

  task automatic t_prescale();
    logic [31:0] v;
    do_reset();
    bus_wr(4'h0, 100);
    bus_wr(4'h8, 32'h84);
    bus_wr(4'hC, 0);
    ticks(15);
    bus_rd(4'h4, v); check("R3 div16 before", v, 100);
    ticks(1);
    bus_rd(4'h4, v); check("R3 div16 step", v, 99);
    bus_wr(4'h8, 32'h88);
    ticks(255);
    bus_rd(4'h4, v); check("R3 div256 before", v, 99);
    ticks(1);
    bus_rd(4'h4, v); check("R3 div256 step", v, 98);
    bus_wr(4'h8, 32'h8C);
    ticks(1);
    bus_rd(4'h4, v); check("R3 code 11 as div1", v, 97);
  endtask

  task automatic t_free_down();
    logic [31:0] v;
    do_reset();
    bus_wr(4'h0, 1);
    bus_wr(4'h8, 32'h80);
    bus_wr(4'hC, 32'hDEAD);
    ticks(1);
    bus_rd(4'h4, v); check("R4 decrement", v, 0);
    check("R4 no irq", {31'd0, irq_o}, 0);
    @(negedge clk); tick_in = 1'b1;
    @(negedge clk); tick_in = 1'b0;
    bus_rd(4'h4, v); check("R4 wrap", v, 32'hFFFF);
    check("R4 irq pulse", {31'd0, irq_o}, 1);
    @(negedge clk);
    check("R4 irq one cycle", {31'd0, irq_o}, 0);
  endtask

  task automatic t_up();
    logic [31:0] v;
    do_reset();
    bus_wr(4'h0, 32'hFFFE);
    bus_wr(4'h8, 32'h1C0);
    bus_wr(4'hC, 0);
    ticks(1);
    bus_rd(4'h4, v); check("R5 increment", v, 32'hFFFF);
    @(negedge clk); tick_in = 1'b1;
    @(negedge clk); tick_in = 1'b0;
    bus_rd(4'h4, v); check("R5 periodic reload", v, 32'hFFFE);
    check("R5 periodic irq", {31'd0, irq_o}, 1);
    bus_wr(4'h0, 32'hFFFF);
    bus_wr(4'h8, 32'h180);
    bus_wr(4'hC, 0);
    @(negedge clk); tick_in = 1'b1;
    @(negedge clk); tick_in = 1'b0;
    bus_rd(4'h4, v); check("R5 free wrap to 0", v, 0);
    check("R5 free irq", {31'd0, irq_o}, 1);
  endtask

  task automatic t_periodic_down();
    logic [31:0] v;
    do_reset();
    bus_wr(4'h0, 2);
    bus_wr(4'h8, 32'hC0);
    bus_wr(4'hC, 0);
    ticks(2);
    bus_rd(4'h4, v); check("R6 reach zero", v, 0);
    @(negedge clk); tick_in = 1'b1;
    @(negedge clk); tick_in = 1'b0;
    bus_rd(4'h4, v); check("R6 reload", v, 2);
    check("R6 irq", {31'd0, irq_o}, 1);
  endtask

  task automatic t_wd_reset();
    logic [31:0] v;
    do_reset();
    bus_wr(4'h0, 3);
    bus_wr(4'h8, 32'h20);
    bus_rd(4'h4, v); check("R7 entry loads", v, 3);
    ticks(2);
    bus_rd(4'h4, v); check("R7 counts without enable", v, 1);
    check("R8 no early reset", {31'd0, rst_req_o}, 0);
    bus_wr(4'h0, 32'h55);
    bus_rd(4'h0, v); check("R11 load locked", v, 3);
    bus_wr(4'h8, 32'h0);
    bus_rd(4'h8, v); check("R11 ctrl locked", v, 32'h20);
    ticks(1);
    check("R8 reset request", {31'd0, rst_req_o}, 1);
    check("R8 no irq", {31'd0, irq_o}, 0);
    bus_wr(4'hC, 0);
    ticks(2);
    check("R8 sticky", {31'd0, rst_req_o}, 1);
    do_reset();
    check("R8 cleared by reset", {31'd0, rst_req_o}, 0);
  endtask

  task automatic t_wd_irq();
    logic [31:0] v;
    do_reset();
    bus_wr(4'h0, 2);
    bus_wr(4'h8, 32'h22);
    ticks(2);
    check("R9 irq pending", {31'd0, irq_o}, 1);
    check("R9 no reset", {31'd0, rst_req_o}, 0);
    ticks(3);
    check("R9 irq held", {31'd0, irq_o}, 1);
    bus_wr(4'hC, 32'h7);
    check("R9 irq cleared", {31'd0, irq_o}, 0);
    bus_rd(4'h4, v); check("R10 clear reloads", v, 2);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    do_reset();
    bus_wr(4'h0, 2);
    bus_wr(4'h8, 32'h22);
    ticks(1);
    @(negedge clk);
    tick_in = 1'b1; bus_addr = 4'hC; wr_data = 0; wr_en = 1'b1;
    @(negedge clk);
    tick_in = 1'b0; wr_en = 1'b0;
    bus_rd(4'h4, v); check("R10 clear wins", v, 2);
    check("R10 no expiry", {31'd0, irq_o}, 0);
    ticks(1);
    check("R10 full period", {31'd0, irq_o}, 0);
    ticks(1);
    check("R10 expires after period", {31'd0, irq_o}, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_ctrl_image();
    t_prescale();
    t_free_down();
    t_up();
    t_periodic_down();
    t_wd_reset();
    t_wd_irq();
    t_collide();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule